// File: doc/BRIEF.md
# Prefix-Selected IP-Relative Branch Unit

This block computes branch targets and updates the program counter (PC) of a small 8-bit CPU. The CPU also keeps two extra registers for a threaded-code virtual machine: an interpretive pointer (IP) and a word register (W). The core hands the block one opcode at a time, together with the status flags. The block then reads its operand bytes through a byte-wide memory read port, updates PC or IP, and drops `busy` when the instruction is finished.

A plain conditional branch reads one signed displacement byte at PC and is relative to PC. A one-shot indirection prefix opcode changes how the next branch works. The branch then reads a 16-bit little-endian displacement at IP, IP steps past both bytes, and a taken branch adds the displacement to the advanced IP. PC only steps past the opcode. Because the branch is relative to IP, interpreted code can branch without synthesizing the jump from many interpreter steps. The core sets PC, IP and W through a small load port while the block is idle.

Top module: `ipbr_unit`

## Requirements
- R1: After reset, `pc`, `ip` and `w` are 0, `prefixActive` is 0, `busy` is 0 and `memRd` is 0.
- R2: A conditional branch without a prefix, at opcode address A, reads one byte at A+1. A taken branch sets PC to A+2 plus that byte sign-extended. A branch that is not taken sets PC to A+2. IP does not change.
- R3: Conditional opcodes have bits [4:0] = 10000. Bits [7:6] pick the flag: 00 N, 01 V, 10 C, 11 Z. The `flags` port carries N on bit 3, V on bit 2, C on bit 1 and Z on bit 0. The branch is taken when the chosen flag equals opcode bit 5. Opcode 0x80 is always taken.
- R4: After the prefix opcode (default 0x0B), a branch reads the low byte at IP and then the high byte at IP+1. A taken branch sets IP to IP+2 plus the 16-bit displacement. PC ends at the branch opcode address plus 1.
- R5: A prefixed branch that is not taken leaves IP at IP+2, and PC at the branch opcode address plus 1.
- R6: The prefix opcode sets `prefixActive`. The flag is cleared when the next instruction completes, whatever its type. A non-branch opcode only advances PC by 1.
- R7: All PC and IP arithmetic wraps modulo 2^16, including operand reads across 0xFFFF.
- R8: `memRd` is high only in operand-fetch cycles, with `memAddr` equal to the byte being read. It is never high while `busy` is low.
- R9: `busy` is high from the cycle after a branch is accepted until it completes. `instValid` and `loadSel` are ignored while `busy` is high.
- R10: While idle with `instValid` low, `loadSel` 1, 2 or 3 writes `loadData` into PC, IP or W. W changes in no other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Opcode present, accepted when idle |
| opcode | input | 8 | Opcode at address `pc` |
| flags | input | 4 | {N, V, C, Z} status flags |
| loadSel | input | 2 | 0 none, 1 PC, 2 IP, 3 W |
| loadData | input | 16 | Value for register load |
| memData | input | 8 | Byte read at `memAddr`, same cycle |
| memAddr | output | 16 | Operand read address |
| memRd | output | 1 | Operand read strobe |
| busy | output | 1 | Branch operand fetch in progress |
| prefixActive | output | 1 | Indirection prefix pending |
| pc | output | 16 | Program counter |
| ip | output | 16 | Interpretive pointer |
| w | output | 16 | Word register |

## Verification
A wrong state register shows up within one cycle of acceptance. A normal branch that wrongly enters the two-byte path keeps `busy` high one cycle too long and puts `memAddr` on IP instead of PC. A prefix flag stuck high or low shows at the very next branch: IP moves when it should not, or PC takes a relative jump it should not. A wrongly latched condition is visible at completion, because PC or IP lands on the taken target or on the fall-through address. A bad low-byte latch shows as an IP off by a multiple of one byte value.

// File: rtl/ipbr_pkg.sv
package ipbr_pkg;
  typedef enum logic [1:0] {LD_NONE = 2'd0, LD_PC = 2'd1, LD_IP = 2'd2, LD_W = 2'd3} loadSel_e;

  typedef struct packed {
    logic pcStep;
    logic pcRel8;
    logic ipStep;
    logic ipRel16;
    logic grabLo;
    logic useIp;
    logic memRd;
    logic ldPc;
    logic ldIp;
    logic ldW;
  } dpCtl_t;
endpackage

// File: rtl/ipbr_ctrl.sv
module ipbr_ctrl
  import ipbr_pkg::*;
#(
  parameter logic [7:0] PREFIX_OP = 8'h0B,
  parameter logic [7:0] ALWAYS_OP = 8'h80
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         instValid,
  input  logic [7:0]   opcode,
  input  logic [3:0]   flags,
  input  logic [1:0]   loadSel,
  output dpCtl_t       ctl,
  output logic         busy,
  output logic         prefixActive
);
  typedef enum logic [1:0] {S_IDLE, S_REL8, S_DLO, S_DHI} state_e;

  state_e stateQ, stateD;
  logic   prefixQ, prefixD;
  logic   takenQ, takenD;
  logic   isCond, isBra, isBranch, isPrefix, flagVal;

  assign isCond   = (opcode[4:0] == 5'b10000);
  assign isBra    = (opcode == ALWAYS_OP);
  assign isBranch = isCond | isBra;
  assign isPrefix = (opcode == PREFIX_OP);

  always_comb begin
    case (opcode[7:6])
      2'd0:    flagVal = flags[3];
      2'd1:    flagVal = flags[2];
      2'd2:    flagVal = flags[1];
      default: flagVal = flags[0];
    endcase
  end

  always_comb begin
    ctl     = '0;
    stateD  = stateQ;
    prefixD = prefixQ;
    takenD  = takenQ;
    case (stateQ)
      S_IDLE: begin
        if (instValid) begin
          ctl.pcStep = 1'b1;
          takenD     = isBra | (flagVal == opcode[5]);
          if (isBranch) begin
            stateD = prefixQ ? S_DLO : S_REL8;
          end else begin
            prefixD = isPrefix;
          end
        end else begin
          ctl.ldPc = (loadSel_e'(loadSel) == LD_PC);
          ctl.ldIp = (loadSel_e'(loadSel) == LD_IP);
          ctl.ldW  = (loadSel_e'(loadSel) == LD_W);
        end
      end
      S_REL8: begin
        ctl.memRd  = 1'b1;
        ctl.pcRel8 = takenQ;
        ctl.pcStep = ~takenQ;
        prefixD    = 1'b0;
        stateD     = S_IDLE;
      end
      S_DLO: begin
        ctl.memRd  = 1'b1;
        ctl.useIp  = 1'b1;
        ctl.grabLo = 1'b1;
        ctl.ipStep = 1'b1;
        stateD     = S_DHI;
      end
      default: begin
        ctl.memRd   = 1'b1;
        ctl.useIp   = 1'b1;
        ctl.ipRel16 = takenQ;
        ctl.ipStep  = ~takenQ;
        prefixD     = 1'b0;
        stateD      = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      prefixQ <= 1'b0;
      takenQ  <= 1'b0;
    end else begin
      stateQ  <= stateD;
      prefixQ <= prefixD;
      takenQ  <= takenD;
    end
  end

  assign busy         = (stateQ != S_IDLE);
  assign prefixActive = prefixQ;
endmodule

// File: rtl/ipbr_dp.sv
module ipbr_dp
  import ipbr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] loadData,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] ip,
  output logic [AW-1:0] w
);
  localparam int DISP_W = 2 * DW;

  logic [AW-1:0]     pcQ, ipQ, wQ;
  logic [DW-1:0]     loQ;
  logic [DISP_W-1:0] disp16;
  logic [AW-1:0]     rel8Ext, rel16Ext, pcNext, ipNext;

  assign disp16   = {memData, loQ};
  assign rel8Ext  = AW'($signed(memData));
  assign rel16Ext = AW'($signed(disp16));
  assign memAddr  = ctl.useIp ? ipQ : pcQ;

  always_comb begin
    pcNext = pcQ;
    if (ctl.ldPc)        pcNext = loadData;
    else if (ctl.pcRel8) pcNext = pcQ + AW'(1) + rel8Ext;
    else if (ctl.pcStep) pcNext = pcQ + AW'(1);
  end

  always_comb begin
    ipNext = ipQ;
    if (ctl.ldIp)         ipNext = loadData;
    else if (ctl.ipRel16) ipNext = ipQ + AW'(1) + rel16Ext;
    else if (ctl.ipStep)  ipNext = ipQ + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= '0;
      ipQ <= '0;
      wQ  <= '0;
      loQ <= '0;
    end else begin
      pcQ <= pcNext;
      ipQ <= ipNext;
      if (ctl.ldW)    wQ  <= loadData;
      if (ctl.grabLo) loQ <= memData;
    end
  end

  assign pc = pcQ;
  assign ip = ipQ;
  assign w  = wQ;
endmodule

// File: rtl/ipbr_unit.sv
module ipbr_unit
  import ipbr_pkg::*;
#(
  parameter int         AW        = 16,
  parameter int         DW        = 8,
  parameter logic [7:0] PREFIX_OP = 8'h0B,
  parameter logic [7:0] ALWAYS_OP = 8'h80
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic [7:0]    opcode,
  input  logic [3:0]    flags,
  input  logic [1:0]    loadSel,
  input  logic [AW-1:0] loadData,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          busy,
  output logic          prefixActive,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] ip,
  output logic [AW-1:0] w
);
  dpCtl_t ctl;

  ipbr_ctrl #(.PREFIX_OP(PREFIX_OP), .ALWAYS_OP(ALWAYS_OP)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opcode(opcode),
    .flags(flags), .loadSel(loadSel), .ctl(ctl), .busy(busy),
    .prefixActive(prefixActive)
  );

  ipbr_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .loadData(loadData),
    .memData(memData), .memAddr(memAddr), .pc(pc), .ip(ip), .w(w)
  );

  assign memRd = ctl.memRd;
endmodule

// File: rtl/ipbr_checker.sv
module ipbr_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          instValid,
  input logic [1:0]    loadSel,
  input logic          memRd,
  input logic          busy,
  input logic          prefixActive,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] ip,
  input logic [AW-1:0] w
);
  a_r8_memrd_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> busy);

  a_r6_prefix_cleared_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !prefixActive);

  a_r2_ip_hold_plain_branch: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !prefixActive) |=> $stable(ip));

  a_r4_pc_hold_prefixed_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (busy && prefixActive) |=> $stable(pc));

  a_r10_w_only_by_load: assert property (@(posedge clk) disable iff (!rstN)
    !(loadSel == 2'd3 && !busy && !instValid) |=> $stable(w));

  a_r9_load_ignored_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && loadSel == 2'd3) |=> $stable(w));
endmodule

bind ipbr_unit ipbr_checker #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .instValid(instValid), .loadSel(loadSel),
  .memRd(memRd), .busy(busy), .prefixActive(prefixActive),
  .pc(pc), .ip(ip), .w(w)
);

// File: tb/sim_ipbr_unit.sv
module sim_ipbr_unit;
  localparam logic [7:0] PFX = 8'h0B;
  localparam logic [7:0] BRA = 8'h80;
  localparam logic [7:0] BEQ = 8'hF0;
  localparam logic [7:0] NOP = 8'hEA;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [3:0]  flags = 4'h0;
  logic [1:0]  loadSel = 2'd0;
  logic [15:0] loadData = 16'h0;
  logic [7:0]  memData;
  logic [15:0] memAddr, pc, ip, w;
  logic        memRd, busy, prefixActive;
  logic [7:0]  mem [0:255];
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;
  assign memData = mem[memAddr[7:0]];

  ipbr_unit u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opcode(opcode),
    .flags(flags), .loadSel(loadSel), .loadData(loadData), .memData(memData),
    .memAddr(memAddr), .memRd(memRd), .busy(busy), .prefixActive(prefixActive),
    .pc(pc), .ip(ip), .w(w)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired (R9 busy never dropped)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadReg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    loadSel = sel; loadData = val;
    @(posedge clk);
    @(negedge clk);
    loadSel = 2'd0;
  endtask

  task automatic exec(input logic [7:0] op);
    @(negedge clk);
    instValid = 1'b1; opcode = op;
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  function automatic logic expTaken(input logic [7:0] op, input logic [3:0] f);
    if (op == BRA) return 1'b1;
    return f[3 - op[7:6]] == op[5];
  endfunction

  task automatic testReset();
    chk("R1 pc", pc, 16'h0);
    chk("R1 ip", ip, 16'h0);
    chk("R1 w", w, 16'h0);
    chk("R1 prefix/busy/memRd", {13'h0, prefixActive, busy, memRd}, 16'h0);
  endtask

  task automatic testPlainBranches();
    loadReg(2'd2, 16'h0300);
    loadReg(2'd1, 16'h0040); mem[8'h41] = 8'h10; flags = 4'b0001;
    exec(BEQ);
    chk("R2 BEQ taken pc", pc, 16'h0052);
    chk("R2 ip unchanged", ip, 16'h0300);
    loadReg(2'd1, 16'h0040); flags = 4'b0000;
    exec(BEQ);
    chk("R3 BEQ not taken pc", pc, 16'h0042);
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 2; p++) begin
        logic [7:0] op;
        logic [3:0] f;
        op = {k[2:0], 5'b10000};
        f = (p == 0) ? 4'b0000 : 4'b1111;
        loadReg(2'd1, 16'h0060); mem[8'h61] = 8'hF0; flags = f;
        exec(op);
        chk($sformatf("R3 op=%h flags=%b", op, f), pc,
            expTaken(op, f) ? 16'h0052 : 16'h0062);
      end
    end
    loadReg(2'd1, 16'h0060); flags = 4'b0000;
    exec(BRA);
    chk("R3 always-taken", pc, 16'h0052);
  endtask

  task automatic testPrefixed();
    loadReg(2'd1, 16'h0040); loadReg(2'd2, 16'h0100);
    mem[8'h00] = 8'h34; mem[8'h01] = 8'h12; flags = 4'b0001;
    exec(PFX);
    chk("R6 prefix set", {15'h0, prefixActive}, 16'h1);
    exec(BEQ);
    chk("R4 taken ip", ip, 16'h1336);
    chk("R4 pc past opcode", pc, 16'h0042);
    chk("R6 prefix cleared after branch", {15'h0, prefixActive}, 16'h0);
    loadReg(2'd1, 16'h0040); loadReg(2'd2, 16'h0100); flags = 4'b0000;
    exec(PFX); exec(BEQ);
    chk("R5 not taken ip", ip, 16'h0102);
    chk("R5 not taken pc", pc, 16'h0042);
  endtask

  task automatic testPrefixOneShot();
    loadReg(2'd1, 16'h0040); loadReg(2'd2, 16'h0200);
    exec(PFX); exec(NOP);
    chk("R6 non-branch pc", pc, 16'h0042);
    chk("R6 prefix cleared by non-branch", {15'h0, prefixActive}, 16'h0);
    mem[8'h43] = 8'h05;
    exec(BRA);
    chk("R6 next branch uses pc", pc, 16'h0049);
    chk("R6 next branch ip untouched", ip, 16'h0200);
  endtask

  task automatic testWrap();
    loadReg(2'd1, 16'hFFFE); mem[8'hFF] = 8'h7F;
    exec(BRA);
    chk("R7 pc wrap forward", pc, 16'h007F);
    loadReg(2'd1, 16'h0000); mem[8'h01] = 8'h80;
    exec(BRA);
    chk("R7 pc wrap backward", pc, 16'hFF82);
    loadReg(2'd2, 16'hFFFF); mem[8'hFF] = 8'h05; mem[8'h00] = 8'h00;
    exec(PFX); exec(BRA);
    chk("R7 ip operand across wrap", ip, 16'h0006);
    loadReg(2'd2, 16'h0010); mem[8'h10] = 8'hF0; mem[8'h11] = 8'hFF;
    exec(PFX); exec(BRA);
    chk("R7 ip negative disp", ip, 16'h0002);
  endtask

  task automatic testPortAndBusy();
    chk("R8 memRd low idle", {15'h0, memRd}, 16'h0);
    loadReg(2'd1, 16'h0080); mem[8'h81] = 8'h04;
    @(negedge clk);
    instValid = 1'b1; opcode = BRA; loadSel = 2'd3; loadData = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    chk("R8 memRd in fetch", {15'h0, memRd}, 16'h1);
    chk("R8 memAddr at pc operand", memAddr, 16'h0081);
    chk("R9 busy during fetch", {15'h0, busy}, 16'h1);
    opcode = NOP;
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0; loadSel = 2'd0;
    chk("R9 pc ignores instValid while busy", pc, 16'h0086);
    chk("R9 w ignores load while busy", w, 16'h0000);
    loadReg(2'd2, 16'h0020); mem[8'h20] = 8'h00; mem[8'h21] = 8'h01;
    exec(PFX);
    @(negedge clk);
    instValid = 1'b1; opcode = BRA;
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0;
    chk("R8 memAddr at ip low", memAddr, 16'h0020);
    @(negedge clk);
    chk("R8 memAddr at ip high", memAddr, 16'h0021);
    @(negedge clk);
    chk("R4 ip after page jump", ip, 16'h0122);
  endtask

  task automatic testWord();
    loadReg(2'd3, 16'hA55A);
    chk("R10 w load", w, 16'hA55A);
    loadReg(2'd1, 16'h0040); mem[8'h41] = 8'h02;
    exec(BRA);
    chk("R10 w kept over branch", w, 16'hA55A);
    chk("R10 pc load then branch", pc, 16'h0044);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlainBranches();
    testPrefixed();
    testPrefixOneShot();
    testWrap();
    testPortAndBusy();
    testWord();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule